// File: doc/BRIEF.md
# UART Transmit Serializer

This block is the serial transmit path of an asynchronous serial port. A parallel character of 5 to 8 bits is written into a holding register. When the shift stage is idle and the transmitter is enabled, the character moves into the shift stage. The shift stage then sends one start bit, the data bits with bit 0 first, an optional parity bit, and one or two stop bits. All bit timing comes from a one-cycle enable pulse that arrives at sixteen times the bit rate. Every bit lasts exactly sixteen of these pulses.

The line output idles at mark (logic 1). It is also held at mark in four cases: while the block is in master reset, while the transmitter is disabled, while the shift stage is empty, and while loop mode is active. In loop mode the frame is sent on a separate loopback output, so the local receiver can take it in. The line output stays silent during loop mode. Two flags let the surrounding logic pace its writes: one reports that the holding register is empty, and one reports that the shift stage is empty.

Top module: `uart_tx_line`

## Requirements
- R1: While `masterReset` (active high, asynchronous) is asserted, `serialOut` and `loopSerial` are 1 and both `holdEmpty` and `shiftEmpty` are 1. A frame in progress and a queued character are both discarded.
- R2: A cycle with `holdLoad` high captures `holdData` into the holding register, and `holdEmpty` reads 0 after that clock edge.
- R3: When `shiftEmpty`=1, `holdEmpty`=0 and `txEnable`=1 in a cycle, the next edge moves the character to the shift stage. After that edge, `holdEmpty`=1, `shiftEmpty`=0 and the start bit (0) is on the line.
- R4: A frame begins with one start bit of 0, followed by the data bits with bit 0 first. The number of data bits is 5, 6, 7 or 8 when `wordLen` is 00, 01, 10 or 11. Holding-register bits above that length have no effect on the frame.
- R5: With `parityEn`=1, one parity bit follows the last data bit. With `parityOdd`=0 the parity is even: data ones plus the parity bit give an even count. With `parityOdd`=1 the count is odd. With `parityEn`=0 no parity bit is sent.
- R6: Stop bits are 1. There is one stop bit when `twoStop`=0 and two when `twoStop`=1. `shiftEmpty` returns to 1 on the pulse that ends the final stop bit, and not before.
- R7: Every frame bit lasts exactly 16 pulses of `tick16`. Clock cycles without a pulse do not advance the frame.
- R8: While `shiftEmpty`=1, both `serialOut` and `loopSerial` are 1 (mark).
- R9: While `loopMode`=1, `serialOut` is 1 and `loopSerial` carries the frame. While `loopMode`=0, `loopSerial` is 1.
- R10: While `txEnable`=0, `serialOut` is 1 and no character leaves the holding register. A frame already in progress keeps its timing and ends on schedule.
- R11: When a load and a transfer fall in the same cycle, the old character goes to the shift stage, the new one stays in the holding register, and `holdEmpty` remains 0.
- R12: A queued character starts one clock cycle after `shiftEmpty` returns to 1. Characters go out in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| masterReset | input | 1 | Asynchronous master reset, active high |
| tick16 | input | 1 | One-cycle enable pulse at sixteen times the bit rate |
| holdData | input | 8 | Character to write into the holding register |
| holdLoad | input | 1 | Write strobe for the holding register |
| wordLen | input | 2 | Data length select: 00=5, 01=6, 10=7, 11=8 bits |
| parityEn | input | 1 | Adds a parity bit when 1 |
| parityOdd | input | 1 | 0 selects even parity, 1 selects odd parity |
| twoStop | input | 1 | 0 selects one stop bit, 1 selects two |
| loopMode | input | 1 | Sends the frame to `loopSerial` and holds `serialOut` at mark |
| txEnable | input | 1 | Allows transfers and drives the line when 1 |
| serialOut | output | 1 | Serial line output, 1 = mark |
| loopSerial | output | 1 | Internal loopback stream for the receiver |
| holdEmpty | output | 1 | Holding register is empty |
| shiftEmpty | output | 1 | Shift stage is idle |

## Verification
A write into the holding register and the move of the previous character into the shift stage can happen on the same clock edge. To provoke this, the bench writes one character while the transmitter is disabled. It then raises `txEnable` in the same cycle as a second write. The result is judged at the ports: `holdEmpty` must stay 0 while the first frame goes out, and the second character must follow one cycle after `shiftEmpty` returns. Both frames are compared bit by bit against frames the bench builds itself. The bench samples each bit after its first and its fifteenth tick, with random idle gaps between ticks.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PARITY,
    PH_STOP
  } txPhase_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic     loadShift;  // move holding register into shift stage
    logic     shiftData;  // advance to next data bit
    txPhase_e phase;      // current frame section
  } txStrobes_t;

endpackage

// File: rtl/uart_tx_datapath.sv
module uart_tx_datapath
  import uart_tx_pkg::*;
#(
  parameter int MIN_DATA_BITS = 5,
  parameter int LEN_SEL_W     = 2,
  parameter int DATA_W        = 8
) (
  input  logic                 clk,
  input  logic                 masterReset,
  input  logic [DATA_W-1:0]    holdData,
  input  logic                 holdLoad,
  input  logic [LEN_SEL_W-1:0] wordLen,
  input  logic                 parityOdd,
  input  txStrobes_t           strobes,
  output logic                 holdEmpty,
  output logic                 lineBit
);

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] lenMask;
  logic              parityBit;
  logic              parityCalc;

  // Mask off bits beyond the selected character length
  always_comb begin
    lenMask = '0;
    for (int i = 0; i < DATA_W; i++) begin
      lenMask[i] = (i < (MIN_DATA_BITS + int'(wordLen)));
    end
    parityCalc = (^(holdReg & lenMask)) ^ parityOdd;
  end

  always_ff @(posedge clk or posedge masterReset) begin
    if (masterReset) begin
      holdReg   <= '0;
      holdEmpty <= 1'b1;
      shiftReg  <= '0;
      parityBit <= 1'b0;
    end else begin
      if (holdLoad) begin
        holdReg <= holdData;
      end
      if (holdLoad) begin
        holdEmpty <= 1'b0;
      end else if (strobes.loadShift) begin
        holdEmpty <= 1'b1;
      end
      if (strobes.loadShift) begin
        shiftReg  <= holdReg & lenMask;
        parityBit <= parityCalc;
      end else if (strobes.shiftData) begin
        shiftReg <= shiftReg >> 1;
      end
    end
  end

  // Line value for the current frame section
  always_comb begin
    unique case (strobes.phase)
      PH_START:  lineBit = 1'b0;
      PH_DATA:   lineBit = shiftReg[0];
      PH_PARITY: lineBit = parityBit;
      default:   lineBit = 1'b1;
    endcase
  end

  AST_LOAD_FILLS_HOLD: assert property (@(posedge clk) disable iff (masterReset)
    holdLoad |=> !holdEmpty) else $error("hold flag not cleared by load"); // R2

  AST_XFER_EMPTIES_HOLD: assert property (@(posedge clk) disable iff (masterReset)
    (strobes.loadShift && !holdLoad) |=> holdEmpty) else $error("hold flag not set by transfer"); // R3

  AST_SAME_CYCLE_KEEPS_FULL: assert property (@(posedge clk) disable iff (masterReset)
    (strobes.loadShift && holdLoad) |=> !holdEmpty) else $error("queued character lost"); // R11

endmodule

// File: rtl/uart_tx_control.sv
module uart_tx_control
  import uart_tx_pkg::*;
#(
  parameter int OVERSAMPLE    = 16,
  parameter int MIN_DATA_BITS = 5,
  parameter int LEN_SEL_W     = 2,
  parameter int DATA_W        = 8
) (
  input  logic                 clk,
  input  logic                 masterReset,
  input  logic                 tick16,
  input  logic                 holdEmpty,
  input  logic                 txEnable,
  input  logic [LEN_SEL_W-1:0] wordLen,
  input  logic                 parityEn,
  input  logic                 twoStop,
  output txStrobes_t           strobes,
  output logic                 shiftEmpty
);

  localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(OVERSAMPLE - 1);
  localparam logic [IDX_W-1:0] IDX_FIRST = IDX_W'(MIN_DATA_BITS - 1);

  txPhase_e         phase, phaseNext;
  logic [CNT_W-1:0] tickCnt, cntNext;
  logic [IDX_W-1:0] bitIdx, idxNext;
  logic [IDX_W-1:0] lastIdx;
  logic             withParity;
  logic             twoStopQ;
  logic             loadShift;
  logic             bitEnd;

  assign shiftEmpty = (phase == PH_IDLE);
  assign loadShift  = shiftEmpty && !holdEmpty && txEnable;
  assign bitEnd     = tick16 && (tickCnt == CNT_LAST) && !shiftEmpty;

  assign strobes.loadShift = loadShift;
  assign strobes.shiftData = bitEnd && (phase == PH_DATA);
  assign strobes.phase     = phase;

  always_comb begin
    phaseNext = phase;
    cntNext   = tickCnt;
    idxNext   = bitIdx;
    if (loadShift) begin
      phaseNext = PH_START;
      cntNext   = '0;
      idxNext   = '0;
    end else if (!shiftEmpty && tick16) begin
      cntNext = (tickCnt == CNT_LAST) ? '0 : tickCnt + 1'b1;
      if (bitEnd) begin
        unique case (phase)
          PH_START: begin
            phaseNext = PH_DATA;
            idxNext   = '0;
          end
          PH_DATA: begin
            if (bitIdx == lastIdx) begin
              phaseNext = withParity ? PH_PARITY : PH_STOP;
              idxNext   = '0;
            end else begin
              idxNext = bitIdx + 1'b1;
            end
          end
          PH_PARITY: begin
            phaseNext = PH_STOP;
            idxNext   = '0;
          end
          PH_STOP: begin
            if (twoStopQ && (bitIdx == '0)) begin
              idxNext = IDX_W'(1);
            end else begin
              phaseNext = PH_IDLE;
            end
          end
          default: phaseNext = PH_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or posedge masterReset) begin
    if (masterReset) begin
      phase      <= PH_IDLE;
      tickCnt    <= '0;
      bitIdx     <= '0;
      lastIdx    <= '0;
      withParity <= 1'b0;
      twoStopQ   <= 1'b0;
    end else begin
      phase   <= phaseNext;
      tickCnt <= cntNext;
      bitIdx  <= idxNext;
      if (loadShift) begin
        lastIdx    <= IDX_FIRST + IDX_W'(wordLen);
        withParity <= parityEn;
        twoStopQ   <= twoStop;
      end
    end
  end

  AST_IDLE_HOLDS_WITHOUT_TICK: assert property (@(posedge clk) disable iff (masterReset)
    (!tick16 && !loadShift) |=> ($stable(phase) && $stable(tickCnt))) else $error("frame advanced without tick"); // R7

  AST_DATA_INDEX_RANGE: assert property (@(posedge clk) disable iff (masterReset)
    (phase == PH_DATA) |-> (bitIdx <= lastIdx)) else $error("data index past length"); // R4

  AST_IDLE_AFTER_STOP: assert property (@(posedge clk) disable iff (masterReset)
    ((phase == PH_IDLE) && ($past(phase) != PH_IDLE)) |-> ($past(phase) == PH_STOP)) else $error("frame ended outside stop"); // R6

  AST_XFER_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (masterReset)
    loadShift |-> (txEnable && !holdEmpty)) else $error("transfer while disabled or empty"); // R10

endmodule

// File: rtl/uart_tx_line.sv
module uart_tx_line
  import uart_tx_pkg::*;
#(
  parameter  int OVERSAMPLE    = 16,
  parameter  int MIN_DATA_BITS = 5,
  parameter  int LEN_SEL_W     = 2,
  localparam int DATA_W        = MIN_DATA_BITS + (1 << LEN_SEL_W) - 1
) (
  input  logic                 clk,
  input  logic                 masterReset,
  input  logic                 tick16,
  input  logic [DATA_W-1:0]    holdData,
  input  logic                 holdLoad,
  input  logic [LEN_SEL_W-1:0] wordLen,
  input  logic                 parityEn,
  input  logic                 parityOdd,
  input  logic                 twoStop,
  input  logic                 loopMode,
  input  logic                 txEnable,
  output logic                 serialOut,
  output logic                 loopSerial,
  output logic                 holdEmpty,
  output logic                 shiftEmpty
);

  txStrobes_t strobes;
  logic       lineBit;

  uart_tx_control #(
    .OVERSAMPLE   (OVERSAMPLE),
    .MIN_DATA_BITS(MIN_DATA_BITS),
    .LEN_SEL_W    (LEN_SEL_W),
    .DATA_W       (DATA_W)
  ) uCtrl (
    .clk        (clk),
    .masterReset(masterReset),
    .tick16     (tick16),
    .holdEmpty  (holdEmpty),
    .txEnable   (txEnable),
    .wordLen    (wordLen),
    .parityEn   (parityEn),
    .twoStop    (twoStop),
    .strobes    (strobes),
    .shiftEmpty (shiftEmpty)
  );

  uart_tx_datapath #(
    .MIN_DATA_BITS(MIN_DATA_BITS),
    .LEN_SEL_W    (LEN_SEL_W),
    .DATA_W       (DATA_W)
  ) uPath (
    .clk        (clk),
    .masterReset(masterReset),
    .holdData   (holdData),
    .holdLoad   (holdLoad),
    .wordLen    (wordLen),
    .parityOdd  (parityOdd),
    .strobes    (strobes),
    .holdEmpty  (holdEmpty),
    .lineBit    (lineBit)
  );

  // Line forced to mark in loop mode or when disabled; idle already yields mark
  assign serialOut  = lineBit | loopMode | ~txEnable;
  assign loopSerial = loopMode ? lineBit : 1'b1;

  AST_MARK_WHEN_EMPTY: assert property (@(posedge clk) disable iff (masterReset)
    shiftEmpty |-> (serialOut && loopSerial)) else $error("space while shifter empty"); // R8

  AST_LOOP_SILENCES_LINE: assert property (@(posedge clk) disable iff (masterReset)
    loopMode |-> serialOut) else $error("line active in loop mode"); // R9

  AST_DISABLED_IS_MARK: assert property (@(posedge clk) disable iff (masterReset)
    !txEnable |-> serialOut) else $error("line active while disabled"); // R10

endmodule

// File: tb/sim_uart_tx_line.sv
module sim_uart_tx_line;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       masterReset, tick16, holdLoad;
  logic [7:0] holdData;
  logic [1:0] wordLen;
  logic       parityEn, parityOdd, twoStop, loopMode, txEnable;
  logic       serialOut, loopSerial, holdEmpty, shiftEmpty;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  uart_tx_line u0 (
    .clk(clk), .masterReset(masterReset), .tick16(tick16),
    .holdData(holdData), .holdLoad(holdLoad), .wordLen(wordLen),
    .parityEn(parityEn), .parityOdd(parityOdd), .twoStop(twoStop),
    .loopMode(loopMode), .txEnable(txEnable),
    .serialOut(serialOut), .loopSerial(loopSerial),
    .holdEmpty(holdEmpty), .shiftEmpty(shiftEmpty)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Expected frame: start, data LSB first, optional parity, stop bits
  function automatic void buildFrame(input logic [7:0] d, input logic [1:0] wl,
                                     input logic pe, input logic po, input logic ts,
                                     output logic [15:0] bits, output int n);
    logic p;
    bits = '1;
    n = 0;
    p = 1'b0;
    bits[n] = 1'b0; n++;
    for (int i = 0; i < 5 + int'(wl); i++) begin
      bits[n] = d[i]; p ^= d[i]; n++;
    end
    if (pe) begin bits[n] = p ^ po; n++; end
    bits[n] = 1'b1; n++;
    if (ts) begin bits[n] = 1'b1; n++; end
  endfunction

  task automatic tickOnce(input int gap);
    for (int g = 0; g < gap; g++) begin
      tick16 = 1'b0;
      @(negedge clk);
    end
    tick16 = 1'b1;
    @(negedge clk);
    tick16 = 1'b0;
  endtask

  task automatic setFmt(input logic [1:0] wl, input logic pe, input logic po, input logic ts);
    wordLen = wl; parityEn = pe; parityOdd = po; twoStop = ts;
  endtask

  // Start bit must already be on the line when called
  task automatic checkFrame(input logic [7:0] d, input bit forcedMark);
    logic [15:0] bits;
    int n;
    buildFrame(d, wordLen, parityEn, parityOdd, twoStop, bits, n);
    for (int b = 0; b < n; b++) begin
      for (int t = 1; t <= 16; t++) begin
        tickOnce(int'($urandom_range(0, 2)));
        if (t == 1 || t == 15) begin
          if (loopMode) begin
            check("R9", "loopback bit", loopSerial, bits[b]);
            check("R9", "line silent in loop", serialOut, 1'b1);
          end else if (forcedMark) begin
            check("R10", "line mark while disabled", serialOut, 1'b1);
          end else begin
            check(b == 0 ? "R4" : "R7", "frame bit", serialOut, bits[b]);
            if (t == 1) check("R9", "loopback idle", loopSerial, 1'b1);
          end
          if (b == n - 1 && t == 15) check("R6", "busy until last tick", shiftEmpty, 1'b0);
        end
      end
    end
    check("R6", "empty after final stop", shiftEmpty, 1'b1);
    check("R8", "mark when empty", serialOut, 1'b1);
  endtask

  task automatic startChar(input logic [7:0] d);
    holdData = d; holdLoad = 1'b1;
    @(negedge clk);
    holdLoad = 1'b0;
    check("R2", "hold full after load", holdEmpty, 1'b0);
    check("R3", "shifter idle before transfer", shiftEmpty, 1'b1);
    @(negedge clk);
    check("R3", "hold empty after transfer", holdEmpty, 1'b1);
    check("R3", "shifter busy after transfer", shiftEmpty, 1'b0);
    if (loopMode) check("R9", "loop start bit", loopSerial, 1'b0);
    else if (txEnable) check("R3", "start bit on line", serialOut, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    masterReset = 1'b1; tick16 = 1'b0; holdLoad = 1'b0; holdData = '0;
    loopMode = 1'b0; txEnable = 1'b1;
    setFmt(2'b11, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check("R1", "reset line", serialOut, 1'b1);
    check("R1", "reset loopback", loopSerial, 1'b1);
    check("R1", "reset hold flag", holdEmpty, 1'b1);
    check("R1", "reset shift flag", shiftEmpty, 1'b1);
    masterReset = 1'b0;
    @(negedge clk);

    // Directed formats (R4 R5 R6)
    setFmt(2'b11, 1'b0, 1'b0, 1'b0); startChar(8'hA5); checkFrame(8'hA5, 1'b0);
    setFmt(2'b00, 1'b1, 1'b0, 1'b0); startChar(8'hFA); checkFrame(8'hFA, 1'b0); // R4 upper bits ignored
    setFmt(2'b10, 1'b1, 1'b1, 1'b1); startChar(8'h3C); checkFrame(8'h3C, 1'b0);
    setFmt(2'b01, 1'b1, 1'b1, 1'b1); startChar(8'h00); checkFrame(8'h00, 1'b0); // R5 odd parity of zero

    // Random frames
    for (int k = 0; k < 20; k++) begin
      logic [7:0] d;
      d = 8'($urandom);
      setFmt(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      startChar(d);
      checkFrame(d, 1'b0);
    end

    // Loop mode (R9)
    loopMode = 1'b1;
    setFmt(2'b11, 1'b1, 1'b0, 1'b0); startChar(8'h6B); checkFrame(8'h6B, 1'b0);
    loopMode = 1'b0;

    // Disabled: no transfer, line mark (R10)
    txEnable = 1'b0;
    setFmt(2'b11, 1'b0, 1'b0, 1'b0);
    holdData = 8'h55; holdLoad = 1'b1;
    @(negedge clk);
    holdLoad = 1'b0;
    for (int k = 0; k < 20; k++) tickOnce(1);
    check("R10", "no transfer while disabled", shiftEmpty, 1'b1);
    check("R10", "character kept while disabled", holdEmpty, 1'b0);
    check("R10", "line mark while disabled", serialOut, 1'b1);

    // Same-cycle load and transfer (R11), then queued start (R12)
    txEnable = 1'b1; holdData = 8'h96; holdLoad = 1'b1;
    @(negedge clk);
    holdLoad = 1'b0;
    check("R11", "new character held", holdEmpty, 1'b0);
    check("R11", "old character shifting", shiftEmpty, 1'b0);
    check("R11", "start bit", serialOut, 1'b0);
    checkFrame(8'h55, 1'b0);
    check("R12", "queued character waiting", holdEmpty, 1'b0);
    @(negedge clk);
    check("R12", "queued start one cycle later", shiftEmpty, 1'b0);
    check("R12", "queued hold drained", holdEmpty, 1'b1);
    check("R12", "queued start bit", serialOut, 1'b0);
    checkFrame(8'h96, 1'b0);

    // Disable mid-frame keeps timing, line mark (R10)
    startChar(8'h00);
    txEnable = 1'b0;
    checkFrame(8'h00, 1'b1);
    txEnable = 1'b1;
    @(negedge clk);

    // Reset mid-frame with a queued character (R1)
    startChar(8'h00);
    holdData = 8'h11; holdLoad = 1'b1;
    @(negedge clk);
    holdLoad = 1'b0;
    for (int k = 0; k < 20; k++) tickOnce(0);
    check("R4", "data bit space before reset", serialOut, 1'b0);
    masterReset = 1'b1;
    #1;
    check("R1", "reset aborts frame line", serialOut, 1'b1);
    check("R1", "reset clears shift flag", shiftEmpty, 1'b1);
    check("R1", "reset drops queued character", holdEmpty, 1'b1);
    @(negedge clk);
    masterReset = 1'b0;
    @(negedge clk);
    setFmt(2'b11, 1'b1, 1'b0, 1'b1); startChar(8'hC3); checkFrame(8'hC3, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule